// File: doc/BRIEF.md
# ADC Conversion Request Arbiter

This block decides which channel a single shared sample-and-hold converter handles next. Three command flows compete for it: a regular scan, a hardware-injected chain and a software-injected chain. Each flow carries its own 16-bit channel mask. The block serves the set bits of the mask of the winning flow in ascending channel order, one conversion at a time.

For every conversion the block raises a one-cycle start strobe and presents the channel number and the serving flow. It then holds a sample phase whose length is taken from a 2-bit selector. After the sample phase it waits for a completion strobe from the converter. A one-cycle completion pulse, specific to each flow, marks the end of that flow's chain.

Both injected flows outrank the regular scan. A configuration bit decides which injected flow wins when both are waiting. An injected chain that arrives in the middle of a scan takes over at the next decision point. The scan then continues from the channel after the last one it converted.

Top module: `adc_req_arbiter`

## Requirements
- R1: While and right after synchronous reset, `conv_start`, `smp_active`, `reg_eoc`, `hw_eoi` and `sw_eoi` are low and `conv_chan` is 0.
- R2: A regular command converts the set bits of its mask in ascending channel order with `conv_src` = 0. `reg_eoc` pulses for one cycle, one cycle after the completion strobe of the last channel.
- R3: A hardware-injected command (`conv_src` = 1) or a software-injected command (`conv_src` = 2) converts its own mask in ascending order. It ends with a one-cycle `hw_eoi` or `sw_eoi` pulse, one cycle after the completion strobe of its last channel.
- R4: Pending injected channels are always issued before pending regular channels. A regular scan that an injected chain interrupts resumes with its next unconverted channel.
- R5: When both injected flows are pending at a decision, `sw_first` = 1 issues the software chain first and `sw_first` = 0 issues the hardware chain first.
- R6: `smp_active` is high for exactly 2, 8, 64 or 128 cycles for `smp_sel` = 0, 1, 2 or 3. The count starts with the `conv_start` cycle. The value of `smp_sel` is taken in the cycle of the issue decision.
- R7: Only one conversion is outstanding at a time. No `conv_start` occurs between a sample phase and its completion strobe. A `conv_done` that arrives while idle or during a sample phase is ignored.
- R8: A start whose mask is zero is ignored. So is a start for a flow whose chain is still in progress; that chain goes on with its original mask.
- R9: `conv_start` rises two cycles after a start strobe seen while idle, and two cycles after the completion strobe when more channels are pending. After a completion strobe with nothing pending, no `conv_start` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_go | input | 1 | Start strobe of the regular scan |
| reg_mask | input | 16 | Channel mask of the regular scan |
| hw_go | input | 1 | Start strobe of the hardware-injected chain |
| hw_mask | input | 16 | Channel mask of the hardware-injected chain |
| sw_go | input | 1 | Start strobe of the software-injected chain |
| sw_mask | input | 16 | Channel mask of the software-injected chain |
| sw_first | input | 1 | 1: software-injected outranks hardware-injected |
| smp_sel | input | 2 | Sample-phase length code |
| conv_done | input | 1 | Completion strobe from the converter |
| conv_start | output | 1 | One-cycle start of a conversion |
| conv_chan | output | 4 | Channel being converted |
| conv_src | output | 2 | Serving flow: 0 regular, 1 hardware, 2 software |
| smp_active | output | 1 | High during the sample phase |
| reg_eoc | output | 1 | End of the regular chain |
| hw_eoi | output | 1 | End of the hardware-injected chain |
| sw_eoi | output | 1 | End of the software-injected chain |

## Verification
The bench goes after the following corner cases:

- An injected chain that arrives in the middle of a scan. An arbiter that restarts the scan from its first channel, or skips the next one, puts out the wrong channel once the injection ends.
- Both injected flows pending under each setting of `sw_first`. A reversed priority shows up as the wrong `conv_src`.
- A completion strobe that lands inside the sample phase, and one that lands while idle. An arbiter that accepts either one shortens the sample phase or emits a spurious pulse.
- A restart of a busy flow and a zero mask. Accepting either one would change the channel sequence or start an empty chain.

// File: rtl/adc_arb_pkg.sv
package adc_arb_pkg;

    localparam int NUM_SRC = 3;
    localparam int SMP_W   = 8;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_CONVERT = 2'd2,
        ST_NEXT    = 2'd3
    } arb_state_e;

    localparam logic [1:0] SRC_REG = 2'd0;
    localparam logic [1:0] SRC_HW  = 2'd1;
    localparam logic [1:0] SRC_SW  = 2'd2;

    // Sample-phase length in converter clock cycles for each selector code.
    function automatic logic [SMP_W-1:0] smp_len(input logic [1:0] sel);
        logic [SMP_W-1:0] n;
        unique case (sel)
            2'd0:    n = SMP_W'(2);
            2'd1:    n = SMP_W'(8);
            2'd2:    n = SMP_W'(64);
            default: n = SMP_W'(128);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/adc_arb_select.sv
module adc_arb_select
    import adc_arb_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic [NUM_SRC-1:0][NUM_CH-1:0] pend,
    input  logic                           sw_first,
    output logic                           valid,
    output logic [1:0]                     src,
    output logic [CH_W-1:0]                chan
);

    logic [1:0]        hi_src;
    logic [1:0]        lo_src;
    logic [NUM_CH-1:0] hi_mask;
    logic [NUM_CH-1:0] lo_mask;
    logic [NUM_CH-1:0] win_mask;

    always_comb begin
        hi_src  = sw_first ? SRC_SW : SRC_HW;
        lo_src  = sw_first ? SRC_HW : SRC_SW;
        hi_mask = sw_first ? pend[2] : pend[1];
        lo_mask = sw_first ? pend[1] : pend[2];

        valid = |pend;
        if (|hi_mask) begin
            src      = hi_src;
            win_mask = hi_mask;
        end else if (|lo_mask) begin
            src      = lo_src;
            win_mask = lo_mask;
        end else begin
            src      = SRC_REG;
            win_mask = pend[0];
        end

        chan = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (win_mask[i]) chan = CH_W'(i);
        end
    end

endmodule

// File: rtl/adc_arb_smp_timer.sv
module adc_arb_smp_timer
    import adc_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [1:0] sel,
    output logic       expire
);

    logic [SMP_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= smp_len(sel) - SMP_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - SMP_W'(1);
        end
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/adc_req_arbiter.sv
module adc_req_arbiter
    import adc_arb_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_go,
    input  logic [NUM_CH-1:0] reg_mask,
    input  logic              hw_go,
    input  logic [NUM_CH-1:0] hw_mask,
    input  logic              sw_go,
    input  logic [NUM_CH-1:0] sw_mask,
    input  logic              sw_first,
    input  logic [1:0]        smp_sel,
    input  logic              conv_done,
    output logic              conv_start,
    output logic [CH_W-1:0]   conv_chan,
    output logic [1:0]        conv_src,
    output logic              smp_active,
    output logic              reg_eoc,
    output logic              hw_eoi,
    output logic              sw_eoi
);

    arb_state_e                     state_q, state_d;
    logic [NUM_SRC-1:0][NUM_CH-1:0] pend_q;
    logic [NUM_SRC-1:0][NUM_CH-1:0] req_mask;
    logic [NUM_SRC-1:0]             req_go;
    logic [NUM_SRC-1:0]             act_q;
    logic [NUM_SRC-1:0]             accept;
    logic [NUM_SRC-1:0]             fin_set;
    logic [NUM_SRC-1:0]             end_q;
    logic                           pick_valid;
    logic [1:0]                     pick_src;
    logic [CH_W-1:0]                pick_chan;
    logic                           issue;
    logic                           smp_expire;
    logic                           start_q;
    logic [1:0]                     src_q;
    logic [CH_W-1:0]                chan_q;

    assign req_go   = {sw_go, hw_go, reg_go};
    assign req_mask = {sw_mask, hw_mask, reg_mask};

    adc_arb_select #(.NUM_CH(NUM_CH)) u_select (
        .pend     (pend_q),
        .sw_first (sw_first),
        .valid    (pick_valid),
        .src      (pick_src),
        .chan     (pick_chan)
    );

    adc_arb_smp_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (issue),
        .sel    (smp_sel),
        .expire (smp_expire)
    );

    assign issue = pick_valid && (state_q == ST_IDLE || state_q == ST_NEXT);

    // Per-flow acceptance and chain-completion detection.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_flow
        assign accept[s]  = req_go[s] && !act_q[s] && (|req_mask[s]);
        assign fin_set[s] = (state_q == ST_CONVERT) && conv_done &&
                            (src_q == 2'(s)) && (pend_q[s] == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
            end_q  <= '0;
        end else begin
            end_q <= fin_set;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (accept[s]) begin
                    pend_q[s] <= req_mask[s];
                    act_q[s]  <= 1'b1;
                end else begin
                    if (issue && pick_src == 2'(s)) pend_q[s][pick_chan] <= 1'b0;
                    if (fin_set[s]) act_q[s] <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (issue) state_d = ST_SAMPLE;
            ST_SAMPLE:  if (smp_expire) state_d = ST_CONVERT;
            ST_CONVERT: if (conv_done) state_d = ST_NEXT;
            default:    state_d = issue ? ST_SAMPLE : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            start_q <= 1'b0;
            src_q   <= SRC_REG;
            chan_q  <= '0;
        end else begin
            state_q <= state_d;
            start_q <= issue;
            if (issue) begin
                src_q  <= pick_src;
                chan_q <= pick_chan;
            end
        end
    end

    assign conv_start = start_q;
    assign conv_chan  = chan_q;
    assign conv_src   = src_q;
    assign smp_active = (state_q == ST_SAMPLE);
    assign reg_eoc    = end_q[0];
    assign hw_eoi     = end_q[1];
    assign sw_eoi     = end_q[2];

endmodule

// File: rtl/adc_arb_checker.sv
module adc_arb_checker
    import adc_arb_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              conv_start,
    input logic              smp_active,
    input logic              conv_done,
    input logic              reg_eoc,
    input logic              hw_eoi,
    input logic              sw_eoi,
    input logic              issue,
    input logic [1:0]        pick_src,
    input logic [NUM_CH-1:0] hw_pend,
    input logic [NUM_CH-1:0] sw_pend,
    input logic              sw_first,
    input logic [1:0]        smp_sel
);

    logic [SMP_W:0] run_len;
    logic [SMP_W:0] exp_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
            exp_len <= '0;
        end else begin
            if (issue) exp_len <= {1'b0, smp_len(smp_sel)};
            if (conv_start) run_len <= (SMP_W+1)'(1);
            else if (smp_active) run_len <= run_len + (SMP_W+1)'(1);
        end
    end

    assert_start_in_sample_R6: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> smp_active);

    assert_sample_length_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(smp_active) |-> run_len == exp_len);

    assert_single_start_R7: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    assert_one_end_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_eoc, hw_eoi, sw_eoi}));

    assert_end_after_done_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_eoc || hw_eoi || sw_eoi) |-> $past(conv_done));

    assert_injected_first_R4: assert property (@(posedge clk) disable iff (rst)
        (issue && pick_src == SRC_REG) |-> (hw_pend == '0 && sw_pend == '0));

    assert_hw_prio_R5: assert property (@(posedge clk) disable iff (rst)
        (issue && pick_src == SRC_HW) |-> !(sw_first && sw_pend != '0));

    assert_sw_prio_R5: assert property (@(posedge clk) disable iff (rst)
        (issue && pick_src == SRC_SW) |-> !(!sw_first && hw_pend != '0));

endmodule

bind adc_req_arbiter adc_arb_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .conv_start (conv_start),
    .smp_active (smp_active),
    .conv_done  (conv_done),
    .reg_eoc    (reg_eoc),
    .hw_eoi     (hw_eoi),
    .sw_eoi     (sw_eoi),
    .issue      (issue),
    .pick_src   (pick_src),
    .hw_pend    (pend_q[1]),
    .sw_pend    (pend_q[2]),
    .sw_first   (sw_first),
    .smp_sel    (smp_sel)
);

// File: tb/tb_adc_req_arbiter.sv
module tb_adc_req_arbiter;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_go, hw_go, sw_go;
    logic [15:0] reg_mask, hw_mask, sw_mask;
    logic        sw_first;
    logic [1:0]  smp_sel;
    logic        conv_done;
    logic        conv_start;
    logic [3:0]  conv_chan;
    logic [1:0]  conv_src;
    logic        smp_active;
    logic        reg_eoc, hw_eoi, sw_eoi;

    int          n_total = 0;
    int          n_fail  = 0;
    logic [15:0] m_pend [3];
    bit          m_act  [3];
    string       extra_tag = "";

    always #2 clk = ~clk;

    adc_req_arbiter dut (
        .clk(clk), .rst(rst),
        .reg_go(reg_go), .reg_mask(reg_mask),
        .hw_go(hw_go), .hw_mask(hw_mask),
        .sw_go(sw_go), .sw_mask(sw_mask),
        .sw_first(sw_first), .smp_sel(smp_sel),
        .conv_done(conv_done),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_src(conv_src),
        .smp_active(smp_active),
        .reg_eoc(reg_eoc), .hw_eoi(hw_eoi), .sw_eoi(sw_eoi)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    function automatic int exp_len(input logic [1:0] sel);
        case (sel)
            2'd0:    return 2;
            2'd1:    return 8;
            2'd2:    return 64;
            default: return 128;
        endcase
    endfunction

    function automatic int lowest(input logic [15:0] m);
        for (int i = 0; i < 16; i++) if (m[i]) return i;
        return 0;
    endfunction

    function automatic void pick_exp(output int s, output int c);
        int first  = sw_first ? 2 : 1;
        int second = sw_first ? 1 : 2;
        if (m_pend[first] != 0)       s = first;
        else if (m_pend[second] != 0) s = second;
        else                          s = 0;
        c = lowest(m_pend[s]);
    endfunction

    function automatic bit model_busy();
        return (m_pend[0] != 0) || (m_pend[1] != 0) || (m_pend[2] != 0);
    endfunction

    // Drive start strobes for one cycle; the model applies the acceptance rule.
    task automatic drive_starts(input bit rg, input logic [15:0] rm,
                                input bit hg, input logic [15:0] hm,
                                input bit sg, input logic [15:0] sm);
        reg_go = rg; reg_mask = rm;
        hw_go  = hg; hw_mask  = hm;
        sw_go  = sg; sw_mask  = sm;
        if (rg && !m_act[0] && rm != 0) begin m_pend[0] = rm; m_act[0] = 1; end
        if (hg && !m_act[1] && hm != 0) begin m_pend[1] = hm; m_act[1] = 1; end
        if (sg && !m_act[2] && sm != 0) begin m_pend[2] = sm; m_act[2] = 1; end
        @(negedge clk);
        reg_go = 0; hw_go = 0; sw_go = 0;
    endtask

    // Serve one conversion: check issue, sample length, then complete it.
    task automatic serve_one(input bit stray, input bit inj_now,
                             input bit rg, input logic [15:0] rm,
                             input bit hg, input logic [15:0] hm,
                             input bit sg, input logic [15:0] sm,
                             input bit rnd_cfg);
        int s, c, len, n, wait_n;
        string tag;
        logic [2:0] exp_end;
        @(negedge clk);
        chk(conv_start === 1'b1, "R9 start timing", int'(conv_start), 1);
        pick_exp(s, c);
        if (s == 0)                               tag = "R2";
        else if (m_pend[0] != 0)                  tag = "R4";
        else if (m_pend[1] != 0 && m_pend[2] != 0) tag = "R5";
        else                                      tag = "R3";
        if (extra_tag != "") tag = {tag, " ", extra_tag};
        chk(int'(conv_src) == s, {tag, " source"}, int'(conv_src), s);
        chk(int'(conv_chan) == c, {tag, " channel"}, int'(conv_chan), c);
        m_pend[s][c] = 1'b0;
        len = exp_len(smp_sel);
        n = 1;
        for (int k = 0; k < 200; k++) begin
            if (stray && k == 0) conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
            if (!smp_active) break;
            n++;
        end
        chk(n == len, stray ? "R7 stray done in sample" : "R6 sample length", n, len);
        if (inj_now) drive_starts(rg, rm, hg, hm, sg, sm);
        if (rnd_cfg) begin
            sw_first = 1'($urandom_range(0, 1));
            smp_sel  = 2'($urandom_range(0, 3));
        end
        wait_n = $urandom_range(0, 2);
        for (int k = 0; k < wait_n; k++) begin
            chk(!conv_start && !smp_active, "R7 idle while converting", int'(conv_start), 0);
            @(negedge clk);
        end
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        exp_end = (m_pend[s] == 0) ? 3'(1 << s) : 3'b000;
        chk({sw_eoi, hw_eoi, reg_eoc} == exp_end, (s == 0) ? "R2 end pulse" : "R3 end pulse",
            int'({sw_eoi, hw_eoi, reg_eoc}), int'(exp_end));
        if (m_pend[s] == 0) m_act[s] = 0;
    endtask

    task automatic drain();
        while (model_busy()) serve_one(0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk(!conv_start, "R9 no start when empty", int'(conv_start), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL R9 watchdog expired: actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        logic [15:0] rm, hm, sm;
        void'($urandom(32'h1234_5eed));
        rst = 1; reg_go = 0; hw_go = 0; sw_go = 0;
        reg_mask = 0; hw_mask = 0; sw_mask = 0;
        sw_first = 0; smp_sel = 0; conv_done = 0;
        for (int i = 0; i < 3; i++) begin m_pend[i] = 0; m_act[i] = 0; end
        repeat (4) @(negedge clk);
        chk(!conv_start && !smp_active, "R1 reset strobes", int'(conv_start), 0);
        rst = 0;
        @(negedge clk);
        chk(!conv_start, "R1 start low", int'(conv_start), 0);
        chk(!smp_active, "R1 sample low", int'(smp_active), 0);
        chk(conv_chan == 0, "R1 channel zero", int'(conv_chan), 0);
        chk({sw_eoi, hw_eoi, reg_eoc} == 0, "R1 end pulses low", int'({sw_eoi, hw_eoi, reg_eoc}), 0);

        // Zero mask is ignored.
        drive_starts(1, 16'h0000, 1, 16'h0000, 0, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(!conv_start, "R8 zero mask ignored", int'(conv_start), 0);
        end

        // Completion strobe while idle is ignored.
        conv_done = 1;
        @(negedge clk);
        conv_done = 0;
        for (int k = 0; k < 2; k++) begin
            chk(!conv_start && {sw_eoi, hw_eoi, reg_eoc} == 0, "R7 done while idle",
                int'({conv_start, sw_eoi, hw_eoi, reg_eoc}), 0);
            @(negedge clk);
        end

        // Scan interrupted by injection; restart of the busy scan is ignored.
        smp_sel = 0; sw_first = 0;
        drive_starts(1, 16'h00F0, 0, 0, 0, 0);
        serve_one(1, 1, 1, 16'hFFFF, 1, 16'h0001, 0, 0, 0);
        extra_tag = "R8";
        drain();
        extra_tag = "";

        // Both injected flows pending, each priority setting.
        sw_first = 1; smp_sel = 1;
        drive_starts(0, 0, 1, 16'h0003, 1, 16'h0300);
        drain();
        sw_first = 0; smp_sel = 2;
        drive_starts(1, 16'h8001, 1, 16'h0003, 1, 16'h0300);
        drain();
        smp_sel = 3;
        drive_starts(0, 0, 0, 0, 1, 16'h8000);
        drain();

        // Constrained random traffic.
        for (int it = 0; it < 150; it++) begin
            if (!model_busy()) begin
                for (int t = 0; t < 8 && !model_busy(); t++) begin
                    sw_first = 1'($urandom_range(0, 1));
                    smp_sel  = 2'($urandom_range(0, 2));
                    rm = 16'($urandom & $urandom);
                    hm = 16'($urandom & $urandom & $urandom);
                    sm = 16'($urandom & $urandom & $urandom);
                    drive_starts(1'($urandom_range(0, 1)), rm, 1'($urandom_range(0, 1)), hm,
                                 1'($urandom_range(0, 1)), sm);
                end
                if (!model_busy()) drive_starts(1, 16'h0004, 0, 0, 0, 0);
            end
            rm = 16'($urandom & $urandom);
            hm = 16'($urandom & $urandom & $urandom);
            sm = 16'($urandom & $urandom & $urandom);
            serve_one(1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 2) == 0),
                      1'($urandom_range(0, 1)), rm, 1'($urandom_range(0, 1)), hm,
                      1'($urandom_range(0, 1)), sm, 1);
            if (smp_sel == 2'd3) smp_sel = 2'd1;
        end
        drain();
        report();
    end

endmodule